// File: doc/BRIEF.md
# Triggered Record Averager

This block builds a point-by-point average of several captured waveform records. After a start command it arms. Each record is gated either by a rising edge on the trigger line or, in immediate mode, by nothing at all. A record is a run of consecutive valid input samples whose length is chosen at run time. Sample `i` of each record is added into address `i` of an accumulation memory. The memory is an inferred block RAM with a registered, multi-cycle read.

When the configured number of records has been accumulated, the block divides every stored sum by the record count. It then emits the averaged record, address by address, on a ready/valid output stream. A busy level covers the whole run. A single-cycle done pulse marks the acceptance of the last averaged sample.

The accumulation is a read-modify-write through the RAM read pipeline. The write-back is delayed by exactly the read latency, so each old sum meets its own new sample. Before the next record may begin, the block lets the pipeline empty, so an address is never read while its write is still pending.

Top module: `wave_averager`

## Requirements
- R1: While idle, `start` with `rec_len` in 1..MAX_DEPTH raises `busy` on the next cycle; `start` with `rec_len` of 0 or above MAX_DEPTH is ignored and `busy` stays low.
- R2: In triggered mode (`mode_imm`=0 at start), a record begins only in the cycle after a rising edge of `trig` (high now, low the cycle before); valid samples that arrive while waiting for that edge are discarded.
- R3: A record takes exactly `rec_len` valid samples, skipping cycles where `s_valid` is low, and writes only addresses 0..`rec_len`-1.
- R4: A trigger edge that arrives while a record is being captured, while the pipeline is settling after a record, or while the averaged output is draining has no effect on the result.
- R5: In immediate mode (`mode_imm`=1 at start), each record begins without a trigger, and the same input data gives the same output as triggered mode.
- R6: The first record of a run overwrites the memory, so no sum from an earlier run leaks into the result; later records add to it, giving at address `i` the sum of sample `i` over all NUM_REC records.
- R7: The write-back of each sum takes place RD_LAT cycles after its read, and no address is read while a write-back to it is still in flight.
- R8: After NUM_REC records, exactly `rec_len` outputs are produced in address order 0,1,...; each output is the signed sum divided by NUM_REC and truncated toward zero.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged.
- R10: `done` pulses high for one cycle when the last output is accepted, and `busy` is low in that same cycle.
- R11: During reset and right after it, `busy`, `m_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an averaging run (sampled when idle) |
| mode_imm | input | 1 | 1: records begin without trigger; 0: each waits for a trigger rising edge |
| rec_len | input | $clog2(MAX_DEPTH+1) | Samples per record, 1..MAX_DEPTH |
| s_valid | input | 1 | Input sample strobe |
| s_data | input | SAMPLE_W | Signed input sample |
| trig | input | 1 | Trigger line, edge-detected |
| m_valid | output | 1 | Averaged sample available |
| m_data | output | SAMPLE_W | Signed averaged sample |
| m_ready | input | 1 | Downstream accepts the averaged sample |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the last average is accepted |

## Verification
Random signed records are averaged in triggered mode, then the same records are averaged again in immediate mode, which shows that the gating mode does not change the sums. Constant patterns at the extreme codes and a pattern with a negative non-integer mean show whether the sum overflows and whether the divide rounds toward zero or toward minus infinity. Lengths of one and of the full depth stress the read-modify-write timing and the address limits. Junk samples before a trigger and trigger pulses during capture, settling and drain show whether anything outside a gated record reaches the memory. Back-to-back runs with new data expose any stale sum, and heavy output backpressure checks that the stream holds its data.

// File: rtl/wavg_pkg.sv
package wavg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CAPT,
    ST_SETTLE,
    ST_RD,
    ST_WAIT,
    ST_OUT
  } wavg_st_e;
endpackage

// File: rtl/wavg_rst_sync.sv
module wavg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wavg_edge.sv
module wavg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/wavg_ram.sv
module wavg_ram #(
  parameter int DW     = 20,
  parameter int DEPTH  = 2048,
  parameter int RD_LAT = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] stg [RD_LAT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read plus RD_LAT-1 output stages.
  always_ff @(posedge clk) begin
    if (rd_en) stg[0] <= mem[rd_addr];
    for (int k = 1; k < RD_LAT; k++) stg[k] <= stg[k-1];
  end

  assign rd_data = stg[RD_LAT-1];
endmodule

// File: rtl/wavg_div.sv
module wavg_div #(
  parameter int IN_W    = 20,
  parameter int OUT_W   = 16,
  parameter int DIVISOR = 10
) (
  input  logic signed [IN_W-1:0]  num,
  output logic signed [OUT_W-1:0] quo
);
  localparam bit IS_POW2 = ((DIVISOR & (DIVISOR - 1)) == 0);
  localparam int SH      = (DIVISOR > 1) ? $clog2(DIVISOR) : 0;

  logic signed [IN_W-1:0] q_full;

  generate
    if (IS_POW2) begin : g_shift
      // Bias negatives so the arithmetic shift truncates toward zero.
      logic signed [IN_W-1:0] bias;
      assign bias   = num[IN_W-1] ? IN_W'(DIVISOR - 1) : '0;
      assign q_full = (num + bias) >>> SH;
    end else begin : g_const_div
      localparam logic signed [IN_W-1:0] DV = IN_W'(DIVISOR);
      assign q_full = num / DV;
    end
  endgenerate

  assign quo = q_full[OUT_W-1:0];
endmodule

// File: rtl/wave_averager.sv
module wave_averager #(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_REC   = 10,
  parameter int MAX_DEPTH = 2048,
  parameter int RD_LAT    = 2,
  localparam int ADDR_W   = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int LEN_W    = $clog2(MAX_DEPTH + 1),
  localparam int ACC_W    = SAMPLE_W + $clog2(NUM_REC),
  localparam int CNT_W    = $clog2(NUM_REC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       mode_imm,
  input  logic [LEN_W-1:0]           rec_len,
  input  logic                       s_valid,
  input  logic signed [SAMPLE_W-1:0] s_data,
  input  logic                       trig,
  output logic                       m_valid,
  output logic signed [SAMPLE_W-1:0] m_data,
  input  logic                       m_ready,
  output logic                       busy,
  output logic                       done
);
  import wavg_pkg::*;

  logic rst_sync_n;
  logic trig_rise;

  wavg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));
  wavg_edge     u_edge (.clk(clk), .rst_n(rst_sync_n), .sig(trig), .rise(trig_rise));

  // Control state
  wavg_st_e                   state_q, state_nx;
  logic [ADDR_W-1:0]          idx_q, idx_nx;
  logic [CNT_W-1:0]           rec_q, rec_nx;
  logic [LEN_W-1:0]           len_q, len_nx;
  logic                       imm_q, imm_nx;
  logic                       mv_q, mv_nx;
  logic signed [SAMPLE_W-1:0] md_q, md_nx;
  logic                       done_q, done_nx;

  // Issue side of the read pipeline
  logic                       iss_vld, iss_acc, iss_first;
  logic [ADDR_W-1:0]          iss_addr;
  logic signed [SAMPLE_W-1:0] iss_smp;

  // Pipeline tracking reads in flight
  logic [RD_LAT-1:0]          pv, pacc, pfirst;
  logic [ADDR_W-1:0]          paddr [RD_LAT];
  logic signed [SAMPLE_W-1:0] psmp  [RD_LAT];
  logic                       pipe_busy;

  logic                       t_vld, t_acc, t_first;
  logic [ADDR_W-1:0]          t_addr;
  logic signed [SAMPLE_W-1:0] t_smp;
  logic signed [ACC_W-1:0]    smp_ext;

  logic [ACC_W-1:0]           rd_data;
  logic                       wr_en;
  logic signed [ACC_W-1:0]    wr_data;
  logic signed [SAMPLE_W-1:0] quo;

  logic start_ok, last_idx;

  assign start_ok = start && (rec_len != '0) && (rec_len <= LEN_W'(MAX_DEPTH));
  assign last_idx = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));

  // Issue decode
  always_comb begin
    iss_vld   = 1'b0;
    iss_acc   = 1'b0;
    iss_first = 1'b0;
    iss_addr  = idx_q;
    iss_smp   = s_data;
    if (state_q == ST_CAPT && s_valid) begin
      iss_vld   = 1'b1;
      iss_acc   = 1'b1;
      iss_first = (rec_q == '0);
    end else if (state_q == ST_RD) begin
      iss_vld   = 1'b1;
    end
  end

  // Pipeline registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pv <= '0;
    end else begin
      pv[0] <= iss_vld;
      for (int k = 1; k < RD_LAT; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pacc[0]   <= iss_acc;
    pfirst[0] <= iss_first;
    paddr[0]  <= iss_addr;
    psmp[0]   <= iss_smp;
    for (int k = 1; k < RD_LAT; k++) begin
      pacc[k]   <= pacc[k-1];
      pfirst[k] <= pfirst[k-1];
      paddr[k]  <= paddr[k-1];
      psmp[k]   <= psmp[k-1];
    end
  end

  assign pipe_busy = |pv;
  assign t_vld     = pv[RD_LAT-1];
  assign t_acc     = pacc[RD_LAT-1];
  assign t_first   = pfirst[RD_LAT-1];
  assign t_addr    = paddr[RD_LAT-1];
  assign t_smp     = psmp[RD_LAT-1];
  assign smp_ext   = ACC_W'(t_smp);

  // Write-back: first record overwrites, later ones add
  assign wr_en   = t_vld && t_acc;
  assign wr_data = t_first ? smp_ext : ($signed(rd_data) + smp_ext);

  wavg_ram #(.DW(ACC_W), .DEPTH(MAX_DEPTH), .RD_LAT(RD_LAT)) u_ram (
    .clk    (clk),
    .rd_en  (iss_vld),
    .rd_addr(iss_addr),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_addr(t_addr),
    .wr_data(wr_data)
  );

  wavg_div #(.IN_W(ACC_W), .OUT_W(SAMPLE_W), .DIVISOR(NUM_REC)) u_div (
    .num($signed(rd_data)),
    .quo(quo)
  );

  // Next-state logic
  always_comb begin
    state_nx = state_q;
    idx_nx   = idx_q;
    rec_nx   = rec_q;
    len_nx   = len_q;
    imm_nx   = imm_q;
    mv_nx    = mv_q;
    md_nx    = md_q;
    done_nx  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          len_nx   = rec_len;
          imm_nx   = mode_imm;
          rec_nx   = '0;
          idx_nx   = '0;
          state_nx = ST_ARM;
        end
      end
      ST_ARM: begin
        idx_nx = '0;
        if (imm_q || trig_rise) state_nx = ST_CAPT;
      end
      ST_CAPT: begin
        if (s_valid) begin
          if (last_idx) begin
            idx_nx   = '0;
            rec_nx   = rec_q + CNT_W'(1);
            state_nx = ST_SETTLE;
          end else begin
            idx_nx = idx_q + ADDR_W'(1);
          end
        end
      end
      ST_SETTLE: begin
        if (!pipe_busy) begin
          idx_nx   = '0;
          state_nx = (rec_q == CNT_W'(NUM_REC)) ? ST_RD : ST_ARM;
        end
      end
      ST_RD: begin
        state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (t_vld) begin
          mv_nx    = 1'b1;
          md_nx    = quo;
          state_nx = ST_OUT;
        end
      end
      ST_OUT: begin
        if (m_ready) begin
          mv_nx = 1'b0;
          if (last_idx) begin
            idx_nx   = '0;
            done_nx  = 1'b1;
            state_nx = ST_IDLE;
          end else begin
            idx_nx   = idx_q + ADDR_W'(1);
            state_nx = ST_RD;
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rec_q   <= '0;
      len_q   <= '0;
      imm_q   <= 1'b0;
      mv_q    <= 1'b0;
      md_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      idx_q   <= idx_nx;
      rec_q   <= rec_nx;
      len_q   <= len_nx;
      imm_q   <= imm_nx;
      mv_q    <= mv_nx;
      md_q    <= md_nx;
      done_q  <= done_nx;
    end
  end

  assign m_valid = mv_q;
  assign m_data  = md_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  // Assertions
  generate
    for (genvar g = 0; g < RD_LAT; g++) begin : g_hz
      AST_NO_RAW_HAZARD: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (iss_vld && pv[g] && pacc[g]) |-> (iss_addr != paddr[g])); // R7
    end
  endgenerate

  AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start && ((rec_len == '0) || (rec_len > LEN_W'(MAX_DEPTH)))) |=> !busy); // R1

  AST_WAIT_EDGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ARM && !imm_q && !trig_rise) |=> (state_q != ST_CAPT)); // R2

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    iss_vld |-> (LEN_W'(iss_addr) < len_q)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!busy && !m_valid)); // R10
endmodule

// File: tb/wave_averager_tb.sv
`timescale 1ns/1ps
module wave_averager_tb;
  localparam int SW    = 16;
  localparam int NR    = 10;
  localparam int MD    = 64;
  localparam int LAT   = 3;
  localparam int LEN_W = $clog2(MD + 1);

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic                 mode_imm;
  logic [LEN_W-1:0]     rec_len;
  logic                 s_valid;
  logic signed [SW-1:0] s_data;
  logic                 trig;
  logic                 m_valid;
  logic signed [SW-1:0] m_data;
  logic                 m_ready;
  logic                 busy;
  logic                 done;

  wave_averager #(.SAMPLE_W(SW), .NUM_REC(NR), .MAX_DEPTH(MD), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_imm(mode_imm), .rec_len(rec_len),
    .s_valid(s_valid), .s_data(s_data), .trig(trig), .m_valid(m_valid), .m_data(m_data),
    .m_ready(m_ready), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string cur_tag = "R8";
  int    done_cnt = 0;
  bit    bp = 0;
  int    samp [NR][MD];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected output", int'(m_data), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(m_data) == e, cur_tag, int'(m_data), e);
        end
      end
    end
  end

  // Output backpressure driver
  initial begin
    m_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      m_ready = bp ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // pat: 0 random, 1 negative mean with fraction, 2 min code, 3 max code, -1 keep
  task automatic fill(input int pat);
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < MD; i++)
        case (pat)
          0: samp[r][i] = int'($signed(16'($urandom)));
          1: samp[r][i] = (r == 0) ? 2 : -7;
          2: samp[r][i] = -32768;
          3: samp[r][i] = 32767;
          default: ;
        endcase
  endtask

  task automatic run_case(input bit imm, input int n, input int pat,
                          input string tag, input bit mid);
    int d0;
    int k;
    fill(pat);
    for (int i = 0; i < n; i++) begin
      int s;
      s = 0;
      for (int r = 0; r < NR; r++) s += samp[r][i];
      exp_q.push_back(s / NR); // truncates toward zero
    end
    cur_tag = tag;
    d0 = done_cnt;
    tick();
    rec_len = LEN_W'(n); mode_imm = imm; start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    for (int r = 0; r < NR; r++) begin
      repeat (8) tick();
      if (!imm) begin
        // junk while armed must be discarded (R2)
        for (int j = 0; j < 3; j++) begin
          s_valid = 1'b1; s_data = 16'sd12345; tick();
        end
        s_valid = 1'b0; trig = 1'b1; tick();
        trig = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
        if ($urandom % 3 == 0) begin s_valid = 1'b0; tick(); end
        s_valid = 1'b1; s_data = SW'(samp[r][i]);
        trig = mid && (i == n / 2); // ignored during capture (R4)
        tick();
        trig = 1'b0;
      end
      s_valid = 1'b0;
      if (mid) begin trig = 1'b1; tick(); trig = 1'b0; end // during settle (R4)
    end
    k = 0;
    while (done_cnt == d0 && k < 20000) begin
      trig = mid && (k % 7 == 0); // during drain (R4)
      tick();
      k++;
    end
    trig = 1'b0;
    tick();
    check(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
    check(exp_q.size() == 0, "R8 output count", exp_q.size(), 0);
    check(busy == 1'b0, "R10 idle after done", int'(busy), 0);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_imm = 1'b0; rec_len = '0;
    s_valid = 1'b0; s_data = '0; trig = 1'b0;
    repeat (5) tick();
    check(busy == 1'b0 && m_valid == 1'b0 && done == 1'b0, "R11 in reset",
          int'({busy, m_valid, done}), 0);
    rst_n = 1'b1;
    repeat (5) tick();
    check(busy == 1'b0 && m_valid == 1'b0 && done == 1'b0, "R11 after reset",
          int'({busy, m_valid, done}), 0);

    // R1: out-of-range lengths are refused
    rec_len = '0; start = 1'b1; tick(); start = 1'b0; tick();
    check(busy == 1'b0, "R1 zero length", int'(busy), 0);
    rec_len = LEN_W'(MD + 1); start = 1'b1; tick(); start = 1'b0; tick();
    check(busy == 1'b0, "R1 length above max", int'(busy), 0);

    run_case(1'b0, 16, 0,  "R2 R3 R6 triggered random", 1'b0);
    run_case(1'b1, 16, -1, "R5 immediate same data", 1'b0);
    run_case(1'b0, 16, -1, "R4 stray triggers", 1'b1);
    run_case(1'b1, 1,  0,  "R7 single sample record", 1'b0);
    bp = 1'b1;
    run_case(1'b1, MD, 0,  "R3 R9 full depth backpressure", 1'b0);
    bp = 1'b0;
    run_case(1'b0, 5,  1,  "R8 truncation toward zero", 1'b0);
    run_case(1'b1, 7,  2,  "R6 min code", 1'b0);
    run_case(1'b1, 7,  3,  "R6 max code stale cleared", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule